// File: doc/BRIEF.md
# Fractional Delay Word Slip Unit

This block sits in a word stream and tracks a slowly changing fractional delay. It keeps a 32-bit phase accumulator and an 18-bit per-word increment. Each word that leaves the block, including a repeated one, adds the increment to the accumulator modulo 2^32. When that addition carries out of bit 31, the block adjusts the stream by one word at the next word slot. In repeat mode it presents the previously emitted word once more and holds its input. In skip mode it accepts the next input word and emits nothing for it.

Software writes the starting phase, the increment and the mode over a narrow write port into a shadow set. A frame-start pulse copies the shadow set into the live set at each correlator-frame boundary, so new values take effect together on a frame edge. The stream uses valid/ready handshakes on both sides. When no adjustment is due, input and output are joined without any added latency.

Top module: `delay_slip_unit`

## Requirements
- R1: After reset the shadow and live phase are 0xFFF0_0000, the shadow and live increment are 0x3FFFF and the mode is skip. With no frame start, the sixth input word after reset is dropped and the first five pass.
- R2: When no adjustment is pending, the ports are joined combinationally: out_valid equals in_valid, in_ready equals out_ready, and out_data equals in_data.
- R3: Each emitted word, a repeated one included, adds the live increment to the phase modulo 2^32. A carry out of bit 31 marks an adjustment, which is applied at the next word slot.
- R4: Mode 0 (repeat): when an adjustment is due, the last emitted word is presented again with out_valid high and in_ready low, until out_ready takes it.
- R5: Mode 1 (skip): when an adjustment is due, out_valid is low and in_ready is high whatever out_ready is, and the next input word is consumed without being emitted.
- R6: A write with cfg_sel 0 sets phase bits 15:0 and cfg_sel 1 sets phase bits 31:16. cfg_sel 2 sets increment bits 15:0. cfg_sel 3 sets increment bits 17:16 from cfg_wdata bits 1:0 and the mode from cfg_wdata bit 15. Bits 14:2 of a cfg_sel 3 write are ignored.
- R7: Writes reach only the shadow set. A frame_start pulse copies the shadow phase into the accumulator, copies the shadow increment and mode into the live set, and cancels any pending adjustment.
- R8: While out_valid is high and out_ready low, out_valid stays high and out_data stays stable, provided the source holds its word.
- R9: An increment of zero never causes an adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Shadow register write strobe |
| cfg_sel | input | 2 | Shadow register select |
| cfg_wdata | input | 16 | Shadow register write data |
| frame_start | input | 1 | Frame boundary pulse; loads the live set from the shadow set |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Downstream can take a word |

## Verification
The assertions assume a well-behaved upstream source: once it raises in_valid, it keeps in_valid and in_data unchanged until in_ready takes the word. The stall-stability property depends on this. The bench presents each word and drops in_valid only after the handshake completes. While out_ready is low and a word is on offer, it changes neither the data nor the valid. Frame-start pulses are issued only while the stream is idle, so a reload never falls on a stalled transfer that the stability check is watching.

// File: rtl/dsu_pkg.sv
// Package: shared types and field codes for the delay word slip unit.
// Assumes a 2-bit register select on the shadow write port.
package dsu_pkg;

    // Action taken when the phase accumulator carries out
    typedef enum logic {
        SLIP_REPEAT = 1'b0,
        SLIP_SKIP   = 1'b1
    } slip_mode_e;

    localparam int CFG_SEL_W = 2;

    // Shadow register select codes
    localparam logic [CFG_SEL_W-1:0] SEL_PHASE_LO = 2'd0;
    localparam logic [CFG_SEL_W-1:0] SEL_PHASE_HI = 2'd1;
    localparam logic [CFG_SEL_W-1:0] SEL_INC_LO   = 2'd2;
    localparam logic [CFG_SEL_W-1:0] SEL_INC_HI   = 2'd3;

endpackage

// File: rtl/dsu_shadow_regs.sv
// Module: shadow copy of phase, increment and mode, written over a narrow port.
// Assumes ERR_W == 2*CFG_W and CFG_W < RATE_W < CFG_W + CFG_W - 1.
// The mode bit sits at the top bit of the high-increment write word.
module dsu_shadow_regs
    import dsu_pkg::*;
#(
    parameter int               CFG_W    = 16,
    parameter int               ERR_W    = 32,
    parameter int               RATE_W   = 18,
    parameter logic [ERR_W-1:0]  ERR_RST  = 32'hFFF0_0000,
    parameter logic [RATE_W-1:0] RATE_RST = '1,
    parameter slip_mode_e       MODE_RST = SLIP_SKIP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [ERR_W-1:0]     sh_err,
    output logic [RATE_W-1:0]    sh_rate,
    output slip_mode_e           sh_mode
);

    localparam int ERR_HI_W  = ERR_W - CFG_W;
    localparam int RATE_HI_W = RATE_W - CFG_W;
    localparam int MODE_POS  = CFG_W - 1;

    // Bits between the increment field and the mode bit carry no meaning
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_wdata[MODE_POS-1:RATE_HI_W];

    // Capture software writes into the addressed shadow field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_err  <= ERR_RST;
            sh_rate <= RATE_RST;
            sh_mode <= MODE_RST;
        end else if (cfg_wr_en) begin
            case (cfg_sel)
                SEL_PHASE_LO: sh_err[CFG_W-1:0]      <= cfg_wdata;
                SEL_PHASE_HI: sh_err[ERR_W-1:CFG_W]  <= cfg_wdata[ERR_HI_W-1:0];
                SEL_INC_LO:   sh_rate[CFG_W-1:0]     <= cfg_wdata;
                SEL_INC_HI: begin
                    sh_rate[RATE_W-1:CFG_W] <= cfg_wdata[RATE_HI_W-1:0];
                    sh_mode                 <= slip_mode_e'(cfg_wdata[MODE_POS]);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dsu_phase_acc.sv
// Module: live phase accumulator with its increment and mode.
// Adds the increment once per emitted word and registers the carry as a
// pending adjustment. A frame start reloads from the shadow set and wins
// over a same-cycle step. Assumes step and skip_take never coincide.
module dsu_phase_acc
    import dsu_pkg::*;
#(
    parameter int               ERR_W    = 32,
    parameter int               RATE_W   = 18,
    parameter logic [ERR_W-1:0]  ERR_RST  = 32'hFFF0_0000,
    parameter logic [RATE_W-1:0] RATE_RST = '1,
    parameter slip_mode_e       MODE_RST = SLIP_SKIP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ERR_W-1:0]  sh_err,
    input  logic [RATE_W-1:0] sh_rate,
    input  slip_mode_e        sh_mode,
    input  logic              step,
    input  logic              skip_take,
    output logic              evt_pend,
    output slip_mode_e        mode_act
);

    localparam int PAD_W = ERR_W + 1 - RATE_W;

    logic [ERR_W-1:0]  acc_q;
    logic [RATE_W-1:0] rate_q;
    logic [ERR_W:0]    sum_w;

    // Next phase with the carry in the top bit
    always_comb sum_w = {1'b0, acc_q} + {{PAD_W{1'b0}}, rate_q};

    // Live phase, increment and mode: reload on frame start, advance per word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= ERR_RST;
            rate_q   <= RATE_RST;
            mode_act <= MODE_RST;
        end else if (frame_start) begin
            acc_q    <= sh_err;
            rate_q   <= sh_rate;
            mode_act <= sh_mode;
        end else if (step) begin
            acc_q    <= sum_w[ERR_W-1:0];
        end
    end

    // Pending adjustment: set by carry, cleared by a skip or a frame start
    always_ff @(posedge clk) begin
        if (!rst_n)            evt_pend <= 1'b0;
        else if (frame_start)  evt_pend <= 1'b0;
        else if (step)         evt_pend <= sum_w[ERR_W];
        else if (skip_take)    evt_pend <= 1'b0;
    end

endmodule

// File: rtl/dsu_stream_ctl.sv
// Module: valid/ready steering for pass-through, repeat and skip.
// Joins the ports directly when nothing is pending, replays the last
// emitted word in repeat mode, and swallows one input word in skip mode.
// Assumes the upstream source holds its word until it is accepted.
module dsu_stream_ctl
    import dsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_pend,
    input  slip_mode_e        mode_act,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              step,
    output logic              skip_take
);

    logic              rep_w;
    logic              skp_w;
    logic [DATA_W-1:0] last_word;

    // Decode the pending adjustment into repeat or skip
    always_comb begin
        rep_w = evt_pend && (mode_act == SLIP_REPEAT);
        skp_w = evt_pend && (mode_act == SLIP_SKIP);
    end

    // Port steering for the three cases
    always_comb begin
        if (rep_w) begin
            out_valid = 1'b1;
            out_data  = last_word;
            in_ready  = 1'b0;
        end else if (skp_w) begin
            out_valid = 1'b0;
            out_data  = in_data;
            in_ready  = 1'b1;
        end else begin
            out_valid = in_valid;
            out_data  = in_data;
            in_ready  = out_ready;
        end
    end

    // Handshake events toward the accumulator
    always_comb begin
        step      = out_valid && out_ready;
        skip_take = skp_w && in_valid;
    end

    // Remember the last word passed through, as the source for a repeat
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_word <= '0;
        else if (in_valid && in_ready && !skp_w)
            last_word <= in_data;
    end

endmodule

// File: rtl/delay_slip_unit.sv
// Module: fractional delay word slip unit (top).
// Wires the shadow registers, the live phase accumulator and the stream
// steering together. Assumes frame_start is a single-cycle pulse.
module delay_slip_unit
    import dsu_pkg::*;
#(
    parameter int               DATA_W   = 32,
    parameter int               CFG_W    = 16,
    parameter int               ERR_W    = 32,
    parameter int               RATE_W   = 18,
    parameter logic [ERR_W-1:0]  ERR_RST  = 32'hFFF0_0000,
    parameter logic [RATE_W-1:0] RATE_RST = '1,
    parameter slip_mode_e       MODE_RST = SLIP_SKIP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);

    logic [ERR_W-1:0]  sh_err;
    logic [RATE_W-1:0] sh_rate;
    slip_mode_e        sh_mode;
    logic              evt_pend;
    slip_mode_e        mode_act;
    logic              step;
    logic              skip_take;

    // Software-visible shadow set
    dsu_shadow_regs #(
        .CFG_W(CFG_W), .ERR_W(ERR_W), .RATE_W(RATE_W),
        .ERR_RST(ERR_RST), .RATE_RST(RATE_RST), .MODE_RST(MODE_RST)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .sh_err(sh_err), .sh_rate(sh_rate), .sh_mode(sh_mode)
    );

    // Live phase accumulator
    dsu_phase_acc #(
        .ERR_W(ERR_W), .RATE_W(RATE_W),
        .ERR_RST(ERR_RST), .RATE_RST(RATE_RST), .MODE_RST(MODE_RST)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .sh_err(sh_err), .sh_rate(sh_rate), .sh_mode(sh_mode),
        .step(step), .skip_take(skip_take),
        .evt_pend(evt_pend), .mode_act(mode_act)
    );

    // Stream steering
    dsu_stream_ctl #(
        .DATA_W(DATA_W)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .evt_pend(evt_pend), .mode_act(mode_act),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .step(step), .skip_take(skip_take)
    );

endmodule

// File: rtl/dsu_checker.sv
// Module: protocol and behaviour checks for the delay word slip unit.
// Assumes the upstream source holds in_valid and in_data until accepted.
module dsu_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ready,
    input logic              evt_pend,
    input logic              mode_act
);

    logic [DATA_W-1:0] last_seen;

    // Track the last word that left the block, from the ports alone
    always_ff @(posedge clk) begin
        if (!rst_n)                      last_seen <= '0;
        else if (out_valid && out_ready) last_seen <= out_data;
    end

    // R2: with nothing pending, an input transfer is an output transfer of the same word
    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_pend && in_valid && in_ready) |-> (out_valid && out_ready && out_data == in_data));

    // R4: a due repeat offers the last emitted word and blocks the input
    assert_repeat_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pend && !mode_act) |-> (out_valid && !in_ready && out_data == last_seen));

    // R5: a due skip emits nothing and takes the input
    assert_skip_ports_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pend && mode_act) |-> (!out_valid && in_ready));

    // R5: consuming the skipped word retires the adjustment
    assert_skip_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pend && mode_act && in_valid && !frame_start) |=> !evt_pend);

    // R7: a frame start cancels any pending adjustment
    assert_frame_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !evt_pend);

    // R8: a stalled offer stays valid and stable
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !frame_start) |=> (out_valid && $stable(out_data)));

endmodule

bind delay_slip_unit dsu_checker #(.DATA_W(DATA_W)) u_dsu_checker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .evt_pend(evt_pend), .mode_act(mode_act)
);

// File: tb/tb_delay_slip_unit.sv
`timescale 1ns/1ps
module tb_delay_slip_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic        frame_start;
    logic        in_valid;
    logic [31:0] in_data;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    delay_slip_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    // Stimulus table: phase, increment, mode, carry position k within 8 words (0 = none)
    typedef struct packed {
        logic [31:0] err;
        logic [17:0] rate;
        logic        mode;
        logic [7:0]  k;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'hFFFF_FFF0, 18'h00010, 1'b0, 8'd1},
        '{32'hFFFF_FF00, 18'h00040, 1'b1, 8'd4},
        '{32'hFFFF_0000, 18'h3FFFF, 1'b1, 8'd1},
        '{32'hFFFF_FFFA, 18'h00001, 1'b0, 8'd6},
        '{32'hFFFF_FF80, 18'h00030, 1'b1, 8'd3},
        '{32'hFFFF_FFF9, 18'h00001, 1'b1, 8'd7},
        '{32'hFFFF_FFF8, 18'h00001, 1'b1, 8'd8},
        '{32'h0000_0000, 18'h00001, 1'b0, 8'd0},
        '{32'hFFFF_FFFF, 18'h00000, 1'b0, 8'd0}
    };

    logic [31:0] got [64];
    int          ng = 0;
    logic        collect = 1'b0;

    // Record every output transfer, sampled away from the clock edge
    always @(negedge clk) begin
        if (collect && out_valid && out_ready && ng < 64) begin
            got[ng] = out_data;
            ng = ng + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [15:0] d);
        cfg_sel = s; cfg_wdata = d; cfg_wr_en = 1'b1;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic frame_pulse();
        frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
    endtask

    task automatic load(input logic [31:0] e, input logic [17:0] r, input logic m);
        cfg_write(2'd0, e[15:0]);
        cfg_write(2'd1, e[31:16]);
        cfg_write(2'd2, r[15:0]);
        cfg_write(2'd3, {m, 13'b0, r[17:16]});
        frame_pulse();
    endtask

    task automatic send(input logic [31:0] d);
        in_data = d; in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // Feed n words and compare with the sequence the requirements predict
    task automatic run_stream(input logic m, input int k, input int n,
                              input logic [31:0] base, input string tag);
        logic [31:0] ex [64];
        int ne = 0;
        ng = 0;
        collect = 1'b1;
        for (int i = 0; i < n; i++) send(base + 32'(i));
        repeat (3) @(posedge clk);
        #1;
        collect = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (m && k > 0 && i == k) continue;
            ex[ne] = base + 32'(i); ne++;
            if (!m && k > 0 && i == k - 1) begin
                ex[ne] = base + 32'(i); ne++;
            end
        end
        check({tag, " word count"}, 32'(ng), 32'(ne));
        for (int i = 0; i < ne && i < ng; i++)
            check({tag, " word"}, got[i], ex[i]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        frame_start = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: idle ports after reset
        @(negedge clk);
        check("R2 reset out_valid", 32'(out_valid), 32'd0);
        check("R2 reset in_ready", 32'(in_ready), 32'd1);
        @(posedge clk); #1;

        // R1: reset values, skip after the fifth word
        run_stream(1'b1, 5, 10, 32'hA000_0000, "R1");

        // Table walk covering R3, R4, R5, R7 (cancel), R9
        for (int v = 0; v < NV; v++) begin
            string tag;
            if (VECS[v].k == 0) tag = (VECS[v].rate == 0) ? "R9 vec" : "R3 R7 vec";
            else                tag = VECS[v].mode ? "R3 R5 vec" : "R3 R4 vec";
            load(VECS[v].err, VECS[v].rate, VECS[v].mode);
            run_stream(VECS[v].mode, int'(VECS[v].k), 8, 32'h1000 * 32'(v + 1), tag);
        end

        // R7: shadow writes do not touch the live set until frame start
        load(32'hFFFF_FFF0, 18'h10, 1'b0);
        cfg_write(2'd0, 16'h0000);
        cfg_write(2'd1, 16'h0000);
        cfg_write(2'd2, 16'h0001);
        cfg_write(2'd3, 16'h8000);
        run_stream(1'b0, 1, 4, 32'hB100_0000, "R7 before frame");
        frame_pulse();
        run_stream(1'b1, 0, 4, 32'hB200_0000, "R7 after frame");

        // R4 and R8: repeat held under backpressure
        load(32'hFFFF_FFF0, 18'h10, 1'b0);
        send(32'hD200_0000);
        out_ready = 1'b0; in_valid = 1'b1; in_data = 32'hD2AA_0001;
        @(negedge clk);
        check("R8 stalled out_valid", 32'(out_valid), 32'd1);
        check("R4 repeat data", out_data, 32'hD200_0000);
        check("R4 input held", 32'(in_ready), 32'd0);
        repeat (2) @(negedge clk);
        check("R8 stalled data stable", out_data, 32'hD200_0000);
        @(posedge clk); #1 out_ready = 1'b1;
        @(negedge clk);
        check("R4 repeat offered", out_data, 32'hD200_0000);
        @(posedge clk); #1;
        @(negedge clk);
        check("R2 resume data", out_data, 32'hD2AA_0001);
        check("R2 resume ready", 32'(in_ready), 32'd1);
        @(posedge clk); #1 in_valid = 1'b0;

        // R5: skip consumes the input even with out_ready low
        load(32'hFFFF_FFF0, 18'h10, 1'b1);
        send(32'hD300_0000);
        out_ready = 1'b0; in_valid = 1'b1; in_data = 32'hD3AA_0001;
        @(negedge clk);
        check("R5 skip out_valid", 32'(out_valid), 32'd0);
        check("R5 skip in_ready", 32'(in_ready), 32'd1);
        @(posedge clk); #1 in_data = 32'hD3AA_0002;
        @(negedge clk);
        check("R5 after skip out_valid", 32'(out_valid), 32'd1);
        check("R5 after skip data", out_data, 32'hD3AA_0002);
        check("R2 after skip in_ready", 32'(in_ready), 32'd0);
        @(posedge clk); #1 out_ready = 1'b1;
        @(posedge clk); #1 in_valid = 1'b0;

        // R6: unused bits of the high-increment write are ignored
        cfg_write(2'd0, 16'hFF00);
        cfg_write(2'd1, 16'hFFFF);
        cfg_write(2'd2, 16'h0010);
        cfg_write(2'd3, 16'h7FFC);
        frame_pulse();
        run_stream(1'b0, 16, 20, 32'hE000_0000, "R6 field map");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule